// File: doc/BRIEF.md
# Branch History Table Predictor

This block gives the instruction fetch stage a dynamic guess for the next fetch address. It holds a small direct-mapped table. Each entry holds three things: the upper bits of a branch instruction's address, the last taken target of that branch, and a two-bit history state. In every cycle the current prefetch address is looked up without waiting for a clock edge. If the entry matches and its state predicts taken, the stored target becomes the next fetch address. In every other case the next address is the prefetch address plus one instruction step.

When the execute stage resolves a branch, it presents the branch address, the real outcome, the real target, and the guess that fetch made for that branch. A branch that the table knows has its history state moved along a four-state hysteresis machine. A branch that the table does not know is written into its slot, replacing whatever was there. If the guess was wrong, the block raises a redirect request one cycle later, carrying the address that fetch must restart from.

Top module: `bht_predictor`

## Requirements
- R1: After reset every entry is empty: pred_hit is 0, pred_taken is 0, next_pc equals fetch_pc + PC_STEP, and redirect_valid is 0.
- R2: When fetch_pc hits a valid entry whose state predicts taken, pred_hit and pred_taken are 1 and next_pc is that entry's stored target, in the same cycle.
- R3: On a miss, or on a hit whose state predicts not taken, pred_taken is 0 and next_pc is fetch_pc + PC_STEP.
- R4: The slot is chosen by address bits [5:2]. A hit also needs bits [15:6] to equal the stored tag, so an address that shares a slot but has different upper bits misses.
- R5: A resolved branch that is not in the table is written into its slot, in the weak state of its outcome (2'b10 for taken, 2'b01 for not taken), with the resolved target. Lookups see the new entry from the next cycle on.
- R6: A strong state (2'b11 taken, 2'b00 not taken) that sees one outcome against its prediction moves to the weak state of the same prediction.
- R7: A weak state that sees an outcome against its prediction moves to the strong state of the opposite prediction. Two consecutive wrong outcomes therefore reverse a strong prediction.
- R8: A weak state that sees an outcome matching its prediction returns to the strong state of that prediction. A strong state that sees a matching outcome stays where it is.
- R9: A resolved branch is mispredicted when its outcome differs from ex_pred_taken, or when it was taken to a target other than ex_pred_target. In that case, one cycle later, redirect_valid is 1 and redirect_pc is ex_target if taken, or ex_pc + PC_STEP if not. In every other case redirect_valid is 0 one cycle later.
- R10: When a lookup and an update touch the same entry in the same cycle, the lookup returns the value from before the update, and the update is stored.
- R11: A resolved branch whose slot holds a different tag replaces that entry, and the old branch then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | AW | Current instruction prefetch address |
| pred_hit | output | 1 | fetch_pc matches a valid entry |
| pred_taken | output | 1 | Entry hit and its state predicts taken |
| next_pc | output | AW | Selected next fetch address |
| ex_valid | input | 1 | A resolved branch is presented this cycle |
| ex_pc | input | AW | Address of the resolved branch |
| ex_taken | input | 1 | Real outcome of the branch |
| ex_target | input | AW | Real target of the branch |
| ex_pred_taken | input | 1 | Direction that fetch guessed for this branch |
| ex_pred_target | input | AW | Address that fetch guessed for this branch when taken |
| redirect_valid | output | 1 | Misprediction redirect request |
| redirect_pc | output | AW | Address that fetch must restart from |

## Verification
Lookup results (pred_hit, pred_taken, next_pc) are combinational on fetch_pc and on the table registers. The bench therefore samples them in the same cycle it drives fetch_pc, one time unit after the falling edge. A table write takes effect at the next rising edge, so the effect of an update is looked for in the lookup of the following cycle. For R10, the bench samples the lookup a second time in the update cycle itself, before that rising edge. The redirect outputs are registered, so they are sampled at the falling edge after the rising edge that captured ex_valid.

// File: rtl/bht_pkg.sv
package bht_pkg;

    typedef enum logic [1:0] {
        HS_NT_STRONG = 2'b00,
        HS_NT_WEAK   = 2'b01,
        HS_T_WEAK    = 2'b10,
        HS_T_STRONG  = 2'b11
    } hist_state_e;

    function automatic logic hs_predicts_taken(hist_state_e s);
        return s[1];
    endfunction

    function automatic hist_state_e hs_fresh(logic taken);
        return taken ? HS_T_WEAK : HS_NT_WEAK;
    endfunction

    function automatic hist_state_e hs_advance(hist_state_e s, logic taken);
        hist_state_e n;
        case (s)
            HS_T_STRONG:  n = taken ? HS_T_STRONG : HS_T_WEAK;
            HS_T_WEAK:    n = taken ? HS_T_STRONG : HS_NT_STRONG;
            HS_NT_WEAK:   n = taken ? HS_T_STRONG : HS_NT_STRONG;
            default:      n = taken ? HS_NT_WEAK  : HS_NT_STRONG;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bht_table.sv
module bht_table
    import bht_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 10,
    parameter int AW      = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [AW-1:0]    wr_target,
    input  hist_state_e      wr_state,
    input  logic [IDX_W-1:0] ra_idx,
    output logic             ra_valid,
    output logic [TAG_W-1:0] ra_tag,
    output logic [AW-1:0]    ra_target,
    output hist_state_e      ra_state,
    input  logic [IDX_W-1:0] rb_idx,
    output logic             rb_valid,
    output logic [TAG_W-1:0] rb_tag,
    output logic [AW-1:0]    rb_target,
    output hist_state_e      rb_state
);

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [AW-1:0]    target;
        hist_state_e      state;
    } slot_t;

    slot_t slots [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '{valid: 1'b0, tag: '0, target: '0, state: HS_NT_STRONG};
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                slots[g] <= '{valid: 1'b1, tag: wr_tag, target: wr_target, state: wr_state};
            end
        end
    end

    always_comb begin
        ra_valid  = slots[ra_idx].valid;
        ra_tag    = slots[ra_idx].tag;
        ra_target = slots[ra_idx].target;
        ra_state  = slots[ra_idx].state;
        rb_valid  = slots[rb_idx].valid;
        rb_tag    = slots[rb_idx].tag;
        rb_target = slots[rb_idx].target;
        rb_state  = slots[rb_idx].state;
    end

endmodule

// File: rtl/bht_lookup.sv
module bht_lookup
    import bht_pkg::*;
#(
    parameter int AW      = 16,
    parameter int TAG_W   = 10,
    parameter int PC_STEP = 4
) (
    input  logic [AW-1:0]    fetch_pc,
    input  logic [TAG_W-1:0] fetch_tag,
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [AW-1:0]    ent_target,
    input  hist_state_e      ent_state,
    output logic             hit,
    output logic             taken,
    output logic [AW-1:0]    next_pc
);

    logic [AW-1:0] seq_pc;

    always_comb begin
        seq_pc  = fetch_pc + AW'(PC_STEP);
        hit     = ent_valid && (ent_tag == fetch_tag);
        taken   = hit && hs_predicts_taken(ent_state);
        next_pc = taken ? ent_target : seq_pc;
    end

endmodule

// File: rtl/bht_resolve.sv
module bht_resolve
    import bht_pkg::*;
#(
    parameter int AW      = 16,
    parameter int TAG_W   = 10,
    parameter int PC_STEP = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ex_valid,
    input  logic [AW-1:0]    ex_pc,
    input  logic [TAG_W-1:0] ex_tag,
    input  logic             ex_taken,
    input  logic [AW-1:0]    ex_target,
    input  logic             ex_pred_taken,
    input  logic [AW-1:0]    ex_pred_target,
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [AW-1:0]    ent_target,
    input  hist_state_e      ent_state,
    output logic             wr_en,
    output logic [TAG_W-1:0] wr_tag,
    output logic [AW-1:0]    wr_target,
    output hist_state_e      wr_state,
    output logic             redirect_valid,
    output logic [AW-1:0]    redirect_pc
);

    logic known;
    logic wrong_dir;
    logic wrong_tgt;
    logic [AW-1:0] restart_pc;

    always_comb begin
        known      = ent_valid && (ent_tag == ex_tag);
        wr_en      = ex_valid;
        wr_tag     = ex_tag;
        wr_state   = known ? hs_advance(ent_state, ex_taken) : hs_fresh(ex_taken);
        wr_target  = (ex_taken || !known) ? ex_target : ent_target;
        wrong_dir  = ex_taken != ex_pred_taken;
        wrong_tgt  = ex_taken && ex_pred_taken && (ex_pred_target != ex_target);
        restart_pc = ex_taken ? ex_target : ex_pc + AW'(PC_STEP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= ex_valid && (wrong_dir || wrong_tgt);
            redirect_pc    <= restart_pc;
        end
    end

endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
    import bht_pkg::*;
#(
    parameter int AW      = 16,
    parameter int ENTRIES = 16,
    parameter int PC_STEP = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int OFS_W  = $clog2(PC_STEP),
    localparam int TAG_W  = AW - IDX_W - OFS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] fetch_pc,
    output logic          pred_hit,
    output logic          pred_taken,
    output logic [AW-1:0] next_pc,
    input  logic          ex_valid,
    input  logic [AW-1:0] ex_pc,
    input  logic          ex_taken,
    input  logic [AW-1:0] ex_target,
    input  logic          ex_pred_taken,
    input  logic [AW-1:0] ex_pred_target,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_pc
);

    logic [IDX_W-1:0] f_idx, x_idx;
    logic [TAG_W-1:0] f_tag, x_tag;

    assign f_idx = fetch_pc[OFS_W +: IDX_W];
    assign f_tag = fetch_pc[AW-1 -: TAG_W];
    assign x_idx = ex_pc[OFS_W +: IDX_W];
    assign x_tag = ex_pc[AW-1 -: TAG_W];

    logic             a_valid, b_valid;
    logic [TAG_W-1:0] a_tag, b_tag;
    logic [AW-1:0]    a_target, b_target;
    hist_state_e      a_state, b_state;

    logic             w_en;
    logic [TAG_W-1:0] w_tag;
    logic [AW-1:0]    w_target;
    hist_state_e      w_state;

    bht_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .AW(AW)) u_table (
        .clk(clk), .rst(rst),
        .wr_en(w_en), .wr_idx(x_idx), .wr_tag(w_tag), .wr_target(w_target), .wr_state(w_state),
        .ra_idx(f_idx), .ra_valid(a_valid), .ra_tag(a_tag), .ra_target(a_target), .ra_state(a_state),
        .rb_idx(x_idx), .rb_valid(b_valid), .rb_tag(b_tag), .rb_target(b_target), .rb_state(b_state)
    );

    bht_lookup #(.AW(AW), .TAG_W(TAG_W), .PC_STEP(PC_STEP)) u_lookup (
        .fetch_pc(fetch_pc), .fetch_tag(f_tag),
        .ent_valid(a_valid), .ent_tag(a_tag), .ent_target(a_target), .ent_state(a_state),
        .hit(pred_hit), .taken(pred_taken), .next_pc(next_pc)
    );

    bht_resolve #(.AW(AW), .TAG_W(TAG_W), .PC_STEP(PC_STEP)) u_resolve (
        .clk(clk), .rst(rst),
        .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_tag(x_tag), .ex_taken(ex_taken),
        .ex_target(ex_target), .ex_pred_taken(ex_pred_taken), .ex_pred_target(ex_pred_target),
        .ent_valid(b_valid), .ent_tag(b_tag), .ent_target(b_target), .ent_state(b_state),
        .wr_en(w_en), .wr_tag(w_tag), .wr_target(w_target), .wr_state(w_state),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

endmodule

// File: rtl/bht_predictor_chk.sv
module bht_predictor_chk #(
    parameter int AW      = 16,
    parameter int PC_STEP = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] fetch_pc,
    input logic          pred_hit,
    input logic          pred_taken,
    input logic [AW-1:0] next_pc,
    input logic          ex_valid,
    input logic [AW-1:0] ex_pc,
    input logic          ex_taken,
    input logic [AW-1:0] ex_target,
    input logic          ex_pred_taken,
    input logic          redirect_valid,
    input logic [AW-1:0] redirect_pc
);

    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        pred_taken |-> pred_hit); // R2

    AST_SEQ_WHEN_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        !pred_taken |-> next_pc == fetch_pc + AW'(PC_STEP)); // R3

    AST_ALLOC_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        ex_valid |=> (fetch_pc != $past(ex_pc)) || pred_hit); // R5

    AST_REDIRECT_ON_WRONG_DIR: assert property (@(posedge clk) disable iff (rst)
        ex_valid && (ex_taken != ex_pred_taken) |=> redirect_valid); // R9

    AST_NO_REDIRECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ex_valid |=> !redirect_valid); // R9

    AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (rst)
        ex_valid && ex_taken && !ex_pred_taken |=> redirect_pc == $past(ex_target)); // R9

    AST_REDIRECT_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
        ex_valid && !ex_taken && ex_pred_taken
        |=> redirect_pc == $past(ex_pc) + AW'(PC_STEP)); // R9

endmodule

bind bht_predictor bht_predictor_chk #(.AW(AW), .PC_STEP(PC_STEP)) u_chk (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
    .pred_taken(pred_taken), .next_pc(next_pc), .ex_valid(ex_valid), .ex_pc(ex_pc),
    .ex_taken(ex_taken), .ex_target(ex_target), .ex_pred_taken(ex_pred_taken),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
);

// File: tb/tb_bht_predictor.sv
module tb_bht_predictor;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] fetch_pc;
    logic        pred_hit, pred_taken;
    logic [15:0] next_pc;
    logic        ex_valid, ex_taken, ex_pred_taken;
    logic [15:0] ex_pc, ex_target, ex_pred_target;
    logic        redirect_valid;
    logic [15:0] redirect_pc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    bit          m_valid [16];
    logic [9:0]  m_tag   [16];
    logic [15:0] m_tgt   [16];
    int          m_st    [16];   // 0 NT strong, 1 NT weak, 2 T weak, 3 T strong

    always #(CLK_PERIOD/2) clk = ~clk;

    bht_predictor dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
        .pred_taken(pred_taken), .next_pc(next_pc), .ex_valid(ex_valid), .ex_pc(ex_pc),
        .ex_taken(ex_taken), .ex_target(ex_target), .ex_pred_taken(ex_pred_taken),
        .ex_pred_target(ex_pred_target), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int idx_of(logic [15:0] pc);
        return int'(pc[5:2]);
    endfunction

    function automatic bit m_hit(logic [15:0] pc);
        return m_valid[idx_of(pc)] && m_tag[idx_of(pc)] == pc[15:6];
    endfunction

    function automatic bit m_taken(logic [15:0] pc);
        return m_hit(pc) && m_st[idx_of(pc)] >= 2;
    endfunction

    function automatic logic [15:0] m_next(logic [15:0] pc);
        return m_taken(pc) ? m_tgt[idx_of(pc)] : pc + 16'd4;
    endfunction

    task automatic peek(input logic [15:0] pc, input string req);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        chk(pred_hit == m_hit(pc), {req, " hit"}, int'(pred_hit), int'(m_hit(pc)));
        chk(pred_taken == m_taken(pc), {req, " taken"}, int'(pred_taken), int'(m_taken(pc)));
        chk(next_pc == m_next(pc), {req, " next_pc"}, int'(next_pc), int'(m_next(pc)));
    endtask

    task automatic resolve(input logic [15:0] pc, input bit tk, input logic [15:0] tgt,
                           input string req);
        bit pt, miss, hit;
        logic [15:0] pn, exp_rpc;
        int i, s;
        peek(pc, req);
        pt = m_taken(pc);
        pn = m_next(pc);
        hit = m_hit(pc);
        ex_valid = 1'b1; ex_pc = pc; ex_taken = tk; ex_target = tgt;
        ex_pred_taken = pt; ex_pred_target = pn;
        #1;
        chk(pred_taken == pt && next_pc == pn, "R10 lookup during update",
            int'(next_pc), int'(pn));
        miss = (tk != pt) || (tk && pn != tgt);
        exp_rpc = tk ? tgt : pc + 16'd4;
        i = idx_of(pc);
        if (hit) begin
            s = m_st[i];
            if (tk) s = (s == 0) ? 1 : 3;
            else    s = (s == 3) ? 2 : 0;
            m_st[i] = s;
            if (tk) m_tgt[i] = tgt;
        end else begin
            m_valid[i] = 1; m_tag[i] = pc[15:6]; m_tgt[i] = tgt;
            m_st[i] = tk ? 2 : 1;
        end
        @(posedge clk);
        @(negedge clk);
        ex_valid = 1'b0;
        #1;
        chk(redirect_valid == miss, "R9 redirect_valid", int'(redirect_valid), int'(miss));
        if (miss)
            chk(redirect_pc == exp_rpc, "R9 redirect_pc", int'(redirect_pc), int'(exp_rpc));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] p, q;
        for (int i = 0; i < 16; i++) begin
            m_valid[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_st[i] = 0;
        end
        rst = 1'b1; fetch_pc = 16'h0000; ex_valid = 1'b0; ex_pc = '0; ex_taken = 1'b0;
        ex_target = '0; ex_pred_taken = 1'b0; ex_pred_target = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(redirect_valid == 1'b0, "R1 redirect after reset", int'(redirect_valid), 0);
        for (int i = 0; i < 16; i++) peek(16'(i * 4 + 16'h1200), "R1 empty table");

        // state machine walk on one branch
        p = 16'h3A14;
        resolve(p, 1, 16'h4000, "R5 allocate weak taken");
        peek(p, "R5 entry visible");
        resolve(p, 1, 16'h4000, "R8 weak to strong taken");
        resolve(p, 0, 16'h4000, "R6 strong taken to weak");
        resolve(p, 0, 16'h4000, "R7 second miss flips");
        peek(p, "R7 now not taken");
        resolve(p, 1, 16'h4000, "R6 strong nt to weak");
        resolve(p, 0, 16'h4000, "R8 weak nt to strong");
        resolve(p, 1, 16'h4000, "R6 strong nt again");
        resolve(p, 1, 16'h4040, "R7 flip to taken new target");
        peek(p, "R2 taken to new target");

        // aliasing and replacement
        q = 16'h7F14;
        peek(q, "R4 alias misses");
        resolve(q, 0, 16'h0100, "R11 replace slot");
        peek(p, "R11 old branch gone");
        peek(q, "R3 weak nt sequential");

        // sweep every slot with varied outcomes and tags
        for (int i = 0; i < 16; i++) begin
            for (int k = 0; k < 10; k++) begin
                logic [9:0]  tg;
                logic [15:0] pc, tgt;
                bit tk;
                tg  = (k < 7) ? 10'(i + 1) : 10'(i + 33);
                pc  = {tg, 4'(i), 2'b00};
                tgt = pc + 16'h0040 + 16'(k * 4);
                tk  = ((i * 3 + k * 5) % 7) < 4;
                resolve(pc, tk, tgt, "R2 R3 R6 R7 R8 R11 sweep");
            end
        end
        for (int i = 0; i < 16; i++) peek({10'(i + 1), 4'(i), 2'b00}, "R11 sweep aliases");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule